// File: doc/BRIEF.md
# Clock Control Register Bank

This block holds the configuration words of a clock control unit. It has 26 registers of 32 bits each. A bus master reaches them through a single request port. The port carries a valid strobe, a write flag, a byte offset, an access size and write data. The word index is the byte offset shifted right by two. Only whole, aligned 32-bit accesses are accepted. The block answers every request one cycle later with a ready pulse, registered read data and a flag that marks a rejected access.

Each register has its own reset constant and its own write rule. Some registers take every bit of a write. Some keep only the bits of a mask. The main control register also forces one bit to one on every write. All other registers are read-only to the bus. The contents of all registers are exported in parallel on a flat bus, which feeds the clock-tree logic.

The response path is a small state machine with two states, `ST_IDLE` and `ST_RESP`. From `ST_IDLE`, a request moves it to `ST_RESP`, and no request keeps it in `ST_IDLE`. From `ST_RESP`, a further request keeps it in `ST_RESP` (a back-to-back response), and no request returns it to `ST_IDLE`. The ready output is high exactly while the machine is in `ST_RESP`.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, each word index holds its reset constant, and every index not listed here holds zero:
  - 0 main control: 0x074b0b7d
  - 1 divider A: 0xff870b48
  - 2 divider B: 0x49fcfe7f
  - 3 reset status: 0x007f0000
  - 4 main PLL: 0x04001800
  - 5 USB PLL: 0x04051c03
  - 6 serial PLL: 0x04043001
  - 7 clock-out select: 0x00000280
  - 8, 9 and 10 clock gates: 0xffffffff each
  - 11 wake mask: 0xffffffff
  - 18 tracking word 1: 0x00004040
  - 23 power A: 0x80209828
  - 24 power B: 0x00aa0000
  - 25 divider C: 0x00000285
- R2: A request made while `req_valid` is high is answered on the next cycle with `rsp_ready` high for one cycle. The register index is `req_addr >> 2`. A good read returns that register's value with `rsp_bad` = 0. A good write answers with `rsp_rdata` = 0 and `rsp_bad` = 0. With no request, `rsp_ready` stays low.
- R3: An access is rejected when `req_addr[1:0]` is not zero or when `req_bytes` is not 4. A rejected access answers with `rsp_bad` = 1 and `rsp_rdata` = 0, and it changes no register.
- R4: A read of index 26 or higher answers with `rsp_rdata` = 0 and `rsp_bad` = 1.
- R5: A write to index 0 stores (wdata AND 0x3b6fdfff) OR 0x00000002, so bit 1 reads back as one after any write.
- R6: A write to index 1 stores wdata AND 0xff9f3fff. A write to index 4 or to index 6 stores wdata AND 0xbfff3fff.
- R7: A write to index 2, 8, 9 or 10 stores all 32 bits of wdata.
- R8: A write to any other index changes no register and answers with `rsp_bad` = 1. This covers the read-only indices 3, 5, 7, 11 to 25, and every index of 26 or higher.
- R9: `regs_o[32*i+31 : 32*i]` carries register i. A write becomes visible there on the cycle after the request.
- R10: Requests on consecutive cycles are each answered, in order, one cycle after each was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_bytes | input | 3 | Access size in bytes (1 to 4) |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Registered read data |
| rsp_bad | output | 1 | Access rejected or register absent |
| regs_o | output | 832 | All 26 registers, word i at bits 32*i+31:32*i |

## Verification
The hardest case to reach from the ports is a rejected write aimed at a writable register. The offset is right but the alignment or size is wrong, so only the unchanged exported state shows that the write was dropped. The random stimulus mixes misaligned offsets and short sizes with every index from 0 to 31, and it checks `regs_o` after every request. Directed cases cover three further points:
- the forced bit of the main control register, which reads zero after reset and one after any write;
- a read at the top of the address window;
- a back-to-back burst that mixes good and rejected accesses.

// File: rtl/clkctl_regbank_pkg.sv
package clkctl_regbank_pkg;

    localparam int NREG   = 26;
    localparam int DATA_W = 32;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0:  return 32'h074b0b7d;
            1:  return 32'hff870b48;
            2:  return 32'h49fcfe7f;
            3:  return 32'h007f0000;
            4:  return 32'h04001800;
            5:  return 32'h04051c03;
            6:  return 32'h04043001;
            7:  return 32'h00000280;
            8, 9, 10, 11: return 32'hffffffff;
            18: return 32'h00004040;
            23: return 32'h80209828;
            24: return 32'h00aa0000;
            25: return 32'h00000285;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wr_mask(input int idx);
        case (idx)
            0:          return 32'h3b6fdfff;
            1:          return 32'hff9f3fff;
            4, 6:       return 32'hbfff3fff;
            2, 8, 9, 10: return 32'hffffffff;
            default:    return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wr_force(input int idx);
        return (idx == 0) ? 32'h00000002 : 32'h0;
    endfunction

    function automatic logic is_writable(input int idx);
        case (idx)
            0, 1, 2, 4, 6, 8, 9, 10: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_access_check.sv
module clkctl_access_check
    import clkctl_regbank_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int BYTES_W = 3,
    parameter int IDX_W   = 5,
    parameter int SLOTS   = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTES_W-1:0] bytes,
    input  logic               write,
    input  logic [SLOTS-1:0]   wr_map,
    output logic [IDX_W-1:0]   idx,
    output logic               wr_ok,
    output logic               bad
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0]  NREG_W = WORD_W'(NREG);
    localparam logic [BYTES_W-1:0] FULL   = BYTES_W'(DATA_W / 8);

    logic [WORD_W-1:0] word;
    logic              fmt_ok;
    logic              in_range;

    assign word     = addr[ADDR_W-1:2];
    assign idx      = word[IDX_W-1:0];
    assign fmt_ok   = (addr[1:0] == 2'b00) && (bytes == FULL);
    assign in_range = (word < NREG_W);
    assign wr_ok    = fmt_ok && in_range && wr_map[idx];
    assign bad      = !fmt_ok || (write ? !wr_ok : !in_range);

endmodule

// File: rtl/clkctl_reg_word.sv
module clkctl_reg_word #(
    parameter int              DATA_W = 32,
    parameter logic [DATA_W-1:0] RESET = '0,
    parameter logic [DATA_W-1:0] MASK  = '0,
    parameter logic [DATA_W-1:0] FORCE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RESET;
        else if (wr_en) q <= (wdata & MASK) | FORCE;
    end

    AST_WORD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & ~(MASK | FORCE)) == '0)); // R6

    generate
        if (FORCE != '0) begin : g_force
            AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> ((q & FORCE) == FORCE)); // R5
        end
    endgenerate

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_regbank_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int BYTES_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BYTES_W-1:0]     req_bytes,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_ready,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_bad,
    output logic [NREG*DATA_W-1:0] regs_o
);
    localparam int IDX_W = $clog2(NREG);
    localparam int SLOTS = 2 ** IDX_W;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RESP = 1'b1} rsp_state_e;

    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  wr_map;
    logic [IDX_W-1:0]  idx;
    logic              wr_ok, bad_now;
    logic [DATA_W-1:0] rdata_q;
    logic              bad_q;

    clkctl_access_check #(
        .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .IDX_W(IDX_W), .SLOTS(SLOTS)
    ) check_i (
        .addr(req_addr), .bytes(req_bytes), .write(req_write),
        .wr_map(wr_map), .idx(idx), .wr_ok(wr_ok), .bad(bad_now)
    );

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            if (i < NREG) begin : g_real
                assign regs_o[i*DATA_W +: DATA_W] = slot_q[i];
                if (is_writable(i)) begin : g_rw
                    assign wr_map[i] = 1'b1;
                    clkctl_reg_word #(
                        .DATA_W(DATA_W), .RESET(reset_value(i)),
                        .MASK(wr_mask(i)), .FORCE(wr_force(i))
                    ) word_i (
                        .clk(clk), .rst_n(rst_n),
                        .wr_en(req_valid && req_write && wr_ok && (idx == IDX_W'(i))),
                        .wdata(req_wdata), .q(slot_q[i])
                    );
                end else begin : g_ro
                    assign wr_map[i] = 1'b0;
                    assign slot_q[i] = reset_value(i);
                end
            end else begin : g_pad
                assign wr_map[i] = 1'b0;
                assign slot_q[i] = '0;
            end
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            bad_q   <= 1'b0;
        end else if (req_valid) begin
            rdata_q <= (req_write || bad_now) ? '0 : slot_q[idx];
            bad_q   <= bad_now;
        end else begin
            rdata_q <= '0;
            bad_q   <= 1'b0;
        end
    end

    assign rsp_ready = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_bad   = bad_q;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready); // R2
    AST_BAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && rsp_bad) |-> (rsp_rdata == '0)); // R4
    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_now) |=> $stable(regs_o)); // R8

endmodule

// File: tb/clkctl_regbank_tb_top.sv
module clkctl_regbank_tb_top;
    localparam int NR = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [2:0]    req_bytes = 3'd4;
    logic [31:0]   req_wdata = '0;
    logic          rsp_ready, rsp_bad;
    logic [31:0]   rsp_rdata;
    logic [NR*32-1:0] regs_o;

    int checks = 0, fails = 0;
    logic [31:0] model [NR];

    always #5 clk = ~clk;

    clkctl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_bad(rsp_bad), .regs_o(regs_o)
    );

    function automatic logic [31:0] r1_reset(input int i);
        case (i)
            0: return 32'h074b0b7d;  1: return 32'hff870b48;
            2: return 32'h49fcfe7f;  3: return 32'h007f0000;
            4: return 32'h04001800;  5: return 32'h04051c03;
            6: return 32'h04043001;  7: return 32'h00000280;
            8, 9, 10, 11: return 32'hffffffff;
            18: return 32'h00004040; 23: return 32'h80209828;
            24: return 32'h00aa0000; 25: return 32'h00000285;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_store(input int i, input logic [31:0] d);
        case (i)
            0:    return (d & 32'h3b6fdfff) | 32'h2;
            1:    return d & 32'hff9f3fff;
            4, 6: return d & 32'hbfff3fff;
            default: return d;
        endcase
    endfunction

    function automatic bit writable(input int i);
        return (i == 0 || i == 1 || i == 2 || i == 4 || i == 6 || i == 8 || i == 9 || i == 10);
    endfunction

    function automatic string tag_for(input bit w, input int i, input bit fmt);
        if (!fmt) return "R3";
        if (!w) return (i < NR) ? "R2" : "R4";
        if (i == 0) return "R5";
        if (i == 1 || i == 4 || i == 6) return "R6";
        if (i == 2 || i >= 8 && i <= 10) return "R7";
        return "R8";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        bit ok = 1;
        for (int i = 0; i < NR; i++)
            if (regs_o[i*32 +: 32] !== model[i]) begin
                ok = 0;
                $display("FAIL %s word %0d actual=%h expected=%h", tag, i, regs_o[i*32 +: 32], model[i]);
            end
        checks++;
        if (!ok) fails++;
    endtask

    // Drive at negedge; next negedge response is valid.
    task automatic drive(input bit w, input logic [11:0] a, input logic [2:0] b, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_bytes = b; req_wdata = d;
    endtask

    // Update model and return expected response.
    task automatic predict(input bit w, input logic [11:0] a, input logic [2:0] b, input logic [31:0] d,
                           output logic [31:0] er, output logic eb);
        int i = int'(a >> 2);
        bit fmt = (a[1:0] == 2'b00) && (b == 3'd4);
        er = 32'h0; eb = 1'b0;
        if (!fmt) eb = 1'b1;
        else if (w) begin
            if (writable(i)) model[i] = exp_store(i, d);
            else eb = 1'b1;
        end else if (i < NR) er = model[i];
        else eb = 1'b1;
    endtask

    task automatic do_req(input bit w, input logic [11:0] a, input logic [2:0] b, input logic [31:0] d);
        logic [31:0] er; logic eb;
        string t = tag_for(w, int'(a >> 2), (a[1:0] == 2'b00) && (b == 3'd4));
        @(negedge clk);
        drive(w, a, b, d);
        predict(w, a, b, d, er, eb);
        @(negedge clk);
        req_valid = 1'b0;
        chk({t, " ready"}, {31'b0, rsp_ready}, 32'h1);
        chk({t, " rdata"}, rsp_rdata, er);
        chk({t, " bad"}, {31'b0, rsp_bad}, {31'b0, eb});
        chk_regs({t, " R9 export"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] er0, er1, er2; logic eb0, eb1, eb2;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NR; i++) model[i] = r1_reset(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, no response pending
        chk("R1 idle ready", {31'b0, rsp_ready}, 32'h0);
        chk_regs("R1 reset export");
        for (int i = 0; i < NR; i++) do_req(1'b0, 12'(i * 4), 3'd4, 32'h0);
        // R4 top of window
        do_req(1'b0, 12'hffc, 3'd4, 32'h0);
        do_req(1'b0, 12'd104, 3'd4, 32'h0);
        // R5 forced bit
        do_req(1'b1, 12'h000, 3'd4, 32'h0);
        chk("R5 forced bit", regs_o[31:0], 32'h2);
        do_req(1'b1, 12'h000, 3'd4, 32'hffffffff);
        // R6 / R7 directed
        do_req(1'b1, 12'h004, 3'd4, 32'hffffffff);
        do_req(1'b1, 12'h010, 3'd4, 32'hffffffff);
        do_req(1'b1, 12'h018, 3'd4, 32'hffffffff);
        do_req(1'b1, 12'h020, 3'd4, 32'h12345678);
        do_req(1'b1, 12'h008, 3'd4, 32'h0);
        // R3 rejected writes to writable registers
        do_req(1'b1, 12'h022, 3'd4, 32'h0);
        do_req(1'b1, 12'h024, 3'd2, 32'h0);
        // R8 read-only and out of range
        do_req(1'b1, 12'h00c, 3'd4, 32'h0);
        do_req(1'b1, 12'h064, 3'd4, 32'h0);
        do_req(1'b1, 12'h0f0, 3'd4, 32'h0);
        // R10 back-to-back: good write, bad write, read
        @(negedge clk);
        drive(1'b1, 12'h028, 3'd4, 32'hcafef00d); predict(1'b1, 12'h028, 3'd4, 32'hcafef00d, er0, eb0);
        @(negedge clk);
        chk("R10 b2b#0 rdata", rsp_rdata, er0); chk("R10 b2b#0 bad", {31'b0, rsp_bad}, {31'b0, eb0});
        drive(1'b1, 12'h02d, 3'd4, 32'h0); predict(1'b1, 12'h02d, 3'd4, 32'h0, er1, eb1);
        @(negedge clk);
        chk("R10 b2b#1 ready", {31'b0, rsp_ready}, 32'h1);
        chk("R10 b2b#1 bad", {31'b0, rsp_bad}, {31'b0, eb1});
        drive(1'b0, 12'h028, 3'd4, 32'h0); predict(1'b0, 12'h028, 3'd4, 32'h0, er2, eb2);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 b2b#2 rdata", rsp_rdata, er2); chk("R10 b2b#2 bad", {31'b0, rsp_bad}, {31'b0, eb2});
        chk_regs("R9 b2b export");
        @(negedge clk);
        chk("R2 no request ready", {31'b0, rsp_ready}, 32'h0);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a = 12'(($urandom % 32) * 4);
            logic [2:0]  b = 3'd4;
            if ($urandom % 8 == 0) a[1:0] = 2'($urandom % 4);
            if ($urandom % 8 == 0) b = 3'(1 + $urandom % 3);
            do_req(1'($urandom % 2), a, b, $urandom);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule